// File: doc/BRIEF.md
# Immediate Prefix Extension Unit

This decode-stage block builds the 64-bit immediate operand for a 64-bit soft processor. A consuming instruction carries a 16-bit immediate. Up to two long-immediate prefix instructions may come just before it, and each prefix carries a 24-bit field. The unit keeps the prefix fields in order, places the consumer's 16 bits at the bottom, and sign-extends the result from 16, 40 or 64 bits. The width depends on how many prefixes were held when the consumer issued.

Each cycle the unit receives one decoded instruction: a valid bit, a 2-bit kind code, a 24-bit field, and the pipeline stall and flush controls. A prefix-tracking state machine has the states `PS_IDLE` (no prefix held), `PS_PARTIAL` (some prefixes held, fewer than the maximum) and `PS_FULL` (maximum held). Its transitions are:
- `T_LOAD`: a prefix is accepted in `PS_IDLE` or `PS_PARTIAL`.
- `T_SHIFT`: a prefix is accepted in `PS_FULL`. The oldest field is dropped and the count stays at the maximum.
- `T_ISSUE`: a consumer is accepted, and the state returns to `PS_IDLE`.
- `T_DROP`: a plain instruction is accepted, and the state returns to `PS_IDLE`.
- `T_FLUSH`: a flush occurs, and the state returns to `PS_IDLE`.
- `T_HOLD`: a stall or an invalid slot occurs, and nothing changes.

While a prefix is pending, the unit raises an interrupt-block output. This keeps an interrupt from separating a prefix from its consumer.

Top module: `imm_prefix_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `out_imm` is 0 and `irq_block` is 0.
- R2: A consumer (kind 2'b10) with no prefix before it yields its 16-bit field (`in_field[15:0]`) sign-extended to 64 bits. For example, 0xFFE8 yields 0xFFFFFFFFFFFFFFE8 and 0x1234 yields 0x1234.
- R3: With one prefix (kind 2'b01, 24-bit `in_field`), the result is {prefix, imm16} as a 40-bit value sign-extended to 64 bits. For example, prefix 0xFFAA55 with imm 0x55AA yields 0xFFFFFFFFAA5555AA, and prefix 0x020000 with imm 0x0000 yields 0x0000000200000000.
- R4: With two prefixes, the first one fills bits 63:40, the second fills bits 39:16 and the consumer fills bits 15:0. For example, 0xAA5555 and 0xAAAA55 followed by imm 0x55AA yield 0xAA5555AAAA5555AA.
- R5: A prefix arriving while two are already held shifts out the oldest one, and the count stays at two. For example, prefixes 0x111111, 0x222222 and 0x333333 followed by imm 0x4444 yield 0x2222223333334444.
- R6: `out_valid` is high for exactly the one cycle after each accepted consumer edge. `out_imm` holds its last value until the next consumer issues.
- R7: An issued consumer clears the prefix state, so the next consumer without a prefix sees only its own 16 bits.
- R8: A plain instruction (kind 2'b00 or 2'b11) clears any pending prefix and gives no output strobe.
- R9: `flush` clears the prefix state, and a consumer presented together with `flush` gives no strobe.
- R10: While `stall` is high, the presented instruction is ignored: the prefix state is held and no strobe is given.
- R11: `irq_block` is high on the cycle after a prefix is accepted, and stays high while one or more prefixes are pending. It goes low once the state is cleared.
- R12: A slot with `in_valid` low changes nothing and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A decoded instruction is present |
| in_kind | input | 2 | 00 plain, 01 prefix, 10 consumer, 11 plain |
| in_field | input | 24 | Prefix value, or immediate in bits 15:0 for a consumer |
| stall | input | 1 | Decode stage stalled |
| flush | input | 1 | Pipeline flush |
| out_valid | output | 1 | One-cycle strobe for an issued consumer |
| out_imm | output | 64 | Assembled immediate |
| irq_block | output | 1 | Prefix pending; interrupts must wait |

## Verification
The hardest case to reach is a prefix arriving while the unit is already in `PS_FULL`. Only three accepted prefixes in a row, with no consumer between them, exercise the oldest-field drop. A directed task sends exactly that sequence and then checks which fields survive in the result. Stall and flush cases are made to carry a consumer or a prefix in the same slot. The next consumer's width then shows whether the ignored instruction touched the held state.

// File: rtl/imm_pfx_pkg.sv
package imm_pfx_pkg;

    typedef enum logic [1:0] {
        IK_PLAIN   = 2'b00,
        IK_PREFIX  = 2'b01,
        IK_CONSUME = 2'b10,
        IK_SPARE   = 2'b11
    } instr_kind_e;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'b00,
        PS_PARTIAL = 2'b01,
        PS_FULL    = 2'b10
    } pfx_state_e;

endpackage

// File: rtl/imm_pfx_fsm.sv
module imm_pfx_fsm
    import imm_pfx_pkg::*;
#(
    parameter int MAX_PFX = 2,
    localparam int CNT_W = $clog2(MAX_PFX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             is_pfx,
    input  logic             flush,
    output logic [CNT_W-1:0] count,
    output logic             pending
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PFX);

    pfx_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (flush) begin
            state_d = PS_IDLE;
            cnt_d   = '0;
        end else if (accept) begin
            if (is_pfx) begin
                unique case (state_q)
                    PS_IDLE: begin
                        cnt_d   = CNT_W'(1);
                        state_d = (CNT_MAX == CNT_W'(1)) ? PS_FULL : PS_PARTIAL;
                    end
                    PS_PARTIAL: begin
                        cnt_d   = cnt_q + CNT_W'(1);
                        state_d = (cnt_q + CNT_W'(1) == CNT_MAX) ? PS_FULL : PS_PARTIAL;
                    end
                    PS_FULL: begin
                        cnt_d   = cnt_q;
                        state_d = PS_FULL;
                    end
                    default: begin
                        cnt_d   = '0;
                        state_d = PS_IDLE;
                    end
                endcase
            end else begin
                state_d = PS_IDLE;
                cnt_d   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        count   = cnt_q;
        pending = (state_q != PS_IDLE);
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !flush) |=> $stable(cnt_q) && $stable(state_q));

    // R5
    sat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

endmodule

// File: rtl/imm_pfx_accum.sv
module imm_pfx_accum #(
    parameter int PFX_W   = 24,
    parameter int MAX_PFX = 2,
    localparam int HELD_W = PFX_W * MAX_PFX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [PFX_W-1:0]  field,
    output logic [HELD_W-1:0] held
);

    logic [HELD_W-1:0] held_q, shifted;

    generate
        if (MAX_PFX == 1) begin : g_single
            always_comb shifted = field;
        end else begin : g_chain
            always_comb shifted = {held_q[HELD_W-PFX_W-1:0], field};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     held_q <= '0;
        else if (clear) held_q <= '0;
        else if (load)  held_q <= shifted;
    end

    assign held = held_q;

    // R4
    newest_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> held_q[PFX_W-1:0] == $past(field));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> held_q == '0);

endmodule

// File: rtl/imm_pfx_assemble.sv
module imm_pfx_assemble #(
    parameter int IMM_W   = 16,
    parameter int PFX_W   = 24,
    parameter int MAX_PFX = 2,
    localparam int HELD_W = PFX_W * MAX_PFX,
    localparam int OUT_W  = IMM_W + HELD_W,
    localparam int CNT_W  = $clog2(MAX_PFX + 1)
) (
    input  logic [HELD_W-1:0] held,
    input  logic [IMM_W-1:0]  imm,
    input  logic [CNT_W-1:0]  count,
    output logic [OUT_W-1:0]  value
);

    logic [OUT_W-1:0] raw;
    logic [OUT_W-1:0] cand [MAX_PFX+1];

    assign raw = {held, imm};

    generate
        for (genvar n = 0; n <= MAX_PFX; n++) begin : g_width
            localparam int W = IMM_W + n * PFX_W;
            localparam logic [OUT_W-1:0] MASK = {OUT_W{1'b1}} >> (OUT_W - W);
            assign cand[n] = raw[W-1] ? (raw | ~MASK) : (raw & MASK);
        end
    endgenerate

    always_comb begin
        value = cand[0];
        for (int i = 1; i <= MAX_PFX; i++) begin
            if (count == CNT_W'(i)) value = cand[i];
        end
    end

endmodule

// File: rtl/imm_prefix_unit.sv
module imm_prefix_unit
    import imm_pfx_pkg::*;
#(
    parameter int IMM_W   = 16,
    parameter int PFX_W   = 24,
    parameter int MAX_PFX = 2,
    localparam int OUT_W  = IMM_W + PFX_W * MAX_PFX,
    localparam int CNT_W  = $clog2(MAX_PFX + 1),
    localparam int HELD_W = PFX_W * MAX_PFX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [PFX_W-1:0] in_field,
    input  logic             stall,
    input  logic             flush,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_imm,
    output logic             irq_block
);

    instr_kind_e      kind;
    logic             accept, is_pfx, issue;
    logic [CNT_W-1:0] count;
    logic [HELD_W-1:0] held;
    logic [OUT_W-1:0] asm_value;
    logic             pending;

    always_comb begin
        kind   = instr_kind_e'(in_kind);
        accept = in_valid && !stall && !flush;
        is_pfx = (kind == IK_PREFIX);
        issue  = accept && (kind == IK_CONSUME);
    end

    imm_pfx_fsm #(.MAX_PFX(MAX_PFX)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .is_pfx  (is_pfx),
        .flush   (flush),
        .count   (count),
        .pending (pending)
    );

    imm_pfx_accum #(.PFX_W(PFX_W), .MAX_PFX(MAX_PFX)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept && is_pfx),
        .clear (flush || (accept && !is_pfx)),
        .field (in_field),
        .held  (held)
    );

    imm_pfx_assemble #(.IMM_W(IMM_W), .PFX_W(PFX_W), .MAX_PFX(MAX_PFX)) u_asm (
        .held  (held),
        .imm   (in_field[IMM_W-1:0]),
        .count (count),
        .value (asm_value)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_imm   <= '0;
        end else begin
            out_valid <= issue;
            if (issue) out_imm <= asm_value;
        end
    end

    assign irq_block = pending;

    // R11
    pfx_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_pfx) |=> irq_block);

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!irq_block && !out_valid));

    // R10
    stall_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> (!out_valid && $stable(out_imm)));

    // R7
    issue_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (out_valid && !irq_block));

endmodule

// File: tb/imm_prefix_unit_tb.sv
module imm_prefix_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_kind = 2'b00;
    logic [23:0] in_field = '0;
    logic        stall = 1'b0;
    logic        flush = 1'b0;
    logic        out_valid;
    logic [63:0] out_imm;
    logic        irq_block;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    imm_prefix_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_field(in_field), .stall(stall), .flush(flush),
        .out_valid(out_valid), .out_imm(out_imm), .irq_block(irq_block)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%016h expected 0x%016h", req, got, exp);
        end
    endtask

    task automatic send(input logic v, input logic [1:0] k, input logic [23:0] f,
                        input logic st, input logic fl);
        @(negedge clk);
        in_valid = v; in_kind = k; in_field = f; stall = st; flush = fl;
        @(posedge clk);
        #1;
        in_valid = 1'b0; stall = 1'b0; flush = 1'b0;
    endtask

    task automatic pfx(input logic [23:0] f);
        send(1'b1, 2'b01, f, 1'b0, 1'b0);
    endtask

    task automatic use_imm(input logic [15:0] f);
        send(1'b1, 2'b10, {8'h00, f}, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 out_imm", out_imm, 64'd0);
        check("R1 irq_block", 64'(irq_block), 64'd0);
    endtask

    task automatic t_no_prefix();
        use_imm(16'hFFE8);
        check("R2 valid", 64'(out_valid), 64'd1);
        check("R2 neg", out_imm, 64'hFFFF_FFFF_FFFF_FFE8);
        use_imm(16'h1234);
        check("R2 pos", out_imm, 64'h0000_0000_0000_1234);
        send(1'b0, 2'b00, 24'h0, 1'b0, 1'b0);
        check("R6 strobe one cycle", 64'(out_valid), 64'd0);
        check("R6 value held", out_imm, 64'h1234);
    endtask

    task automatic t_one_prefix();
        pfx(24'hFFAA55);
        check("R11 irq after prefix", 64'(irq_block), 64'd1);
        check("R6 no strobe on prefix", 64'(out_valid), 64'd0);
        use_imm(16'h55AA);
        check("R3 neg40", out_imm, 64'hFFFF_FFFF_AA55_55AA);
        check("R11 irq cleared", 64'(irq_block), 64'd0);
        pfx(24'h020000);
        use_imm(16'h0000);
        check("R3 pos40", out_imm, 64'h0000_0002_0000_0000);
    endtask

    task automatic t_two_prefix();
        pfx(24'hAA5555);
        pfx(24'hAAAA55);
        check("R11 irq with two", 64'(irq_block), 64'd1);
        use_imm(16'h55AA);
        check("R4 full64", out_imm, 64'hAA55_55AA_AA55_55AA);
    endtask

    task automatic t_saturate();
        pfx(24'h111111);
        pfx(24'h222222);
        pfx(24'h333333);
        check("R5 still pending", 64'(irq_block), 64'd1);
        use_imm(16'h4444);
        check("R5 oldest dropped", out_imm, 64'h2222_2233_3333_4444);
    endtask

    task automatic t_clear_on_issue();
        pfx(24'h123456);
        use_imm(16'h0001);
        check("R7 first", out_imm, 64'h0000_0012_3456_0001);
        use_imm(16'h8000);
        check("R7 no stale prefix", out_imm, 64'hFFFF_FFFF_FFFF_8000);
    endtask

    task automatic t_plain();
        pfx(24'h7FFFFF);
        send(1'b1, 2'b00, 24'h00FFFF, 1'b0, 1'b0);
        check("R8 no strobe", 64'(out_valid), 64'd0);
        check("R8 prefix dropped", 64'(irq_block), 64'd0);
        use_imm(16'h0005);
        check("R8 next sees 16b", out_imm, 64'h5);
        pfx(24'h7FFFFF);
        send(1'b1, 2'b11, 24'h00FFFF, 1'b0, 1'b0);
        use_imm(16'h0006);
        check("R8 kind 11 drops", out_imm, 64'h6);
    endtask

    task automatic t_flush();
        pfx(24'h0F0F0F);
        send(1'b1, 2'b10, 24'h00FFFF, 1'b0, 1'b1);
        check("R9 no strobe", 64'(out_valid), 64'd0);
        check("R9 cleared", 64'(irq_block), 64'd0);
        check("R9 out held", out_imm, 64'h6);
        use_imm(16'h0007);
        check("R9 next sees 16b", out_imm, 64'h7);
    endtask

    task automatic t_stall();
        pfx(24'h00ABCD);
        send(1'b1, 2'b10, 24'h00FFFF, 1'b1, 1'b0);
        check("R10 no strobe", 64'(out_valid), 64'd0);
        check("R10 prefix held", 64'(irq_block), 64'd1);
        send(1'b1, 2'b01, 24'h111111, 1'b1, 1'b0);
        send(1'b1, 2'b00, 24'h000000, 1'b1, 1'b0);
        use_imm(16'h0002);
        check("R10 one prefix only", out_imm, 64'h0000_0000_ABCD_0002);
    endtask

    task automatic t_invalid();
        send(1'b0, 2'b01, 24'h012345, 1'b0, 1'b0);
        check("R12 prefix ignored", 64'(irq_block), 64'd0);
        send(1'b0, 2'b10, 24'h000009, 1'b0, 1'b0);
        check("R12 no strobe", 64'(out_valid), 64'd0);
        use_imm(16'hFFFF);
        check("R12 clean", out_imm, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_no_prefix();
        t_one_prefix();
        t_two_prefix();
        t_saturate();
        t_clear_on_issue();
        t_plain();
        t_flush();
        t_stall();
        t_invalid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule